// File: doc/BRIEF.md
# Pixel Frame Control Register Block

This block is the software-facing control point of a streaming pixel processor. Software reaches it over a simple 32-bit register bus with single-cycle write and read strobes. Through that bus it programs the colour format codes, the active frame size, a 3×3 conversion matrix, three per-channel offsets and an output limit window. All of these reach the datapath as static configuration outputs. The block does no pixel arithmetic of its own.

It also sequences frames. A start request launches a frame only if the programmed width and height are both in the legal range. While a frame is active, the datapath is enabled and reports each accepted pixel back to the block. The frame ends after exactly width × height accepted pixels. At that point a one-cycle done pulse is raised, and the block either goes idle or, when continuous mode is set, launches the next frame on the following cycle.

Frame size, formats and matrix coefficients are copied into shadow registers at each launch. Writes made during a frame therefore change what software reads back, but the datapath sees them only from the next frame. Offsets and limits are not shadowed.

Top module: `pixel_frame_ctl`

## Requirements
- R1: After reset, both format codes are 2, the matrix is identity with diagonal value 4096 (1.0 with 12 fraction bits), and all off-diagonal coefficients, offsets and the clamp minimum are 0. The clip maximum is 2^PIX_W−1 (1023 by default), `frame_en` is 0, and the control word reads 4.
- R2: A read strobe returns the addressed register on `reg_rdata` one cycle later, with fields zero-extended. The register map is:
  - control word at 0x000
  - input format at 0x010, output format at 0x018 (codes: 0 RGB, 1 YCrCb 4:4:4, 2 YCrCb 4:2:2, 3 YCrCb 4:2:0)
  - width at 0x020, height at 0x028
  - matrix coefficients row-major from 0x050 to 0x090 in 8-byte steps
  - red, green and blue offsets at 0x098, 0x0A0 and 0x0A8
  - clamp minimum at 0x0B0, clip maximum at 0x0B8

  Any other address, including one not a multiple of 8, reads 0, and writes to it change nothing.
- R3: Writing the control word with bit 0 (start) set while idle, with a legal size, raises `frame_en` from the next cycle. The control word then reads bit 0 = 1 and bit 2 (idle) = 0.
- R4: A legal width is 64 to 8192 and a legal height is 64 to 4320. A start with either value outside its range is refused: `frame_en` stays 0 and the control word keeps reading idle.
- R5: A frame ends on the cycle after its width × height-th accepted pixel. In that cycle `frame_done` and control bit 1 are 1 for exactly one cycle, and `frame_en` is 0.
- R6: With control bit 7 (continuous) clear, the block stays idle after done and the start bit reads 0.
- R7: With control bit 7 set, a new frame starts in the cycle right after the done cycle. Writing 0 to the control word clears continuous mode, and the frame in progress still completes.
- R8: `cfg_width`, `cfg_height`, both format outputs and `cfg_coef` change only when a frame launches. Writes during a frame update the readback value immediately and the outputs at the next launch.
- R9: `cfg_offset`, `cfg_clamp_min` and `cfg_clip_max` follow their registers one cycle after the write.
- R10: `pix_accept` while no frame is active has no effect on the pixel count of the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data, valid one cycle after `reg_rd` |
| pix_accept | input | 1 | Datapath accepted one pixel this cycle |
| frame_en | output | 1 | A frame is active |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_fmt_in | output | 2 | Shadowed input format code |
| cfg_fmt_out | output | 2 | Shadowed output format code |
| cfg_width | output | WID_W | Shadowed active width |
| cfg_height | output | HGT_W | Shadowed active height |
| cfg_coef | output | 9*COEF_W | Shadowed matrix, element k at bits k*COEF_W |
| cfg_offset | output | 3*OFS_W | Red, green and blue offsets, red lowest |
| cfg_clamp_min | output | PIX_W | Lower output limit |
| cfg_clip_max | output | PIX_W | Upper output limit |

## Verification
A wrong pixel counter shows up at the ports as a done pulse that arrives early or late, by the size of the error. That error is visible within one frame, measured in accepted pixels from the first acceptance. A corrupted shadow load shows up at the launch edge as configuration outputs that disagree with the registers just programmed. A broken continuous-mode flag shows up in the cycle right after done, as `frame_en` failing to return, or returning when it should not. A wrong address decode is seen on the very next read, as data landing at the wrong offset or an unmapped address returning nonzero.

// File: rtl/pfc_pkg.sv
package pfc_pkg;

  typedef enum logic [1:0] {
    FMT_RGB   = 2'd0,
    FMT_YC444 = 2'd1,
    FMT_YC422 = 2'd2,
    FMT_YC420 = 2'd3
  } pix_fmt_e;

  // word indices (byte address / 8)
  localparam int IDX_CTRL    = 0;
  localparam int IDX_FMT_IN  = 2;
  localparam int IDX_FMT_OUT = 3;
  localparam int IDX_WIDTH   = 4;
  localparam int IDX_HEIGHT  = 5;
  localparam int IDX_COEF0   = 10;
  localparam int IDX_OFS0    = 19;
  localparam int IDX_CLAMP   = 22;
  localparam int IDX_CLIP    = 23;

  // control word bit positions
  localparam int CB_START = 0;
  localparam int CB_DONE  = 1;
  localparam int CB_IDLE  = 2;
  localparam int CB_AUTO  = 7;

  function automatic logic in_span(input int unsigned v, input int unsigned lo,
                                   input int unsigned hi);
    return (v >= lo) && (v <= hi);
  endfunction

  function automatic logic is_last_pixel(input int unsigned col, input int unsigned row,
                                         input int unsigned w, input int unsigned h);
    return (col + 1 == w) && (row + 1 == h);
  endfunction

endpackage

// File: rtl/pfc_regfile.sv
module pfc_regfile
  import pfc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int WID_W     = 14,
  parameter int HGT_W     = 13,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 12,
  parameter int OFS_W     = 16,
  parameter int PIX_W     = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr,
  input  logic                  rd,
  input  logic [ADDR_W-1:0]     addr,
  input  logic [DATA_W-1:0]     wdata,
  output logic [DATA_W-1:0]     rdata,
  input  logic                  active,
  input  logic                  done,
  output logic [1:0]            fmt_in,
  output logic [1:0]            fmt_out,
  output logic [WID_W-1:0]      width,
  output logic [HGT_W-1:0]      height,
  output logic [9*COEF_W-1:0]   coef,
  output logic [3*OFS_W-1:0]    offs,
  output logic [PIX_W-1:0]      clamp_min,
  output logic [PIX_W-1:0]      clip_max,
  output logic                  auto_rs,
  output logic                  start_wr
);
  localparam int IDX_W = ADDR_W - 3;
  localparam logic [COEF_W-1:0] COEF_ONE = COEF_W'(1) << COEF_FRAC;

  int widx;
  assign widx = (addr[2:0] == 3'b000) ? int'(32'(addr[ADDR_W-1:3])) : -1;

  logic [COEF_W-1:0] coef_q [9];
  logic [OFS_W-1:0]  ofs_q  [3];
  logic [DATA_W-1:0] rd_val;

  assign start_wr = wr && (widx == IDX_CTRL) && wdata[CB_START];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_in    <= FMT_YC422;
      fmt_out   <= FMT_YC422;
      width     <= '0;
      height    <= '0;
      clamp_min <= '0;
      clip_max  <= '1;
      auto_rs   <= 1'b0;
    end else if (wr) begin
      if (widx == IDX_CTRL)    auto_rs   <= wdata[CB_AUTO];
      if (widx == IDX_FMT_IN)  fmt_in    <= wdata[1:0];
      if (widx == IDX_FMT_OUT) fmt_out   <= wdata[1:0];
      if (widx == IDX_WIDTH)   width     <= wdata[WID_W-1:0];
      if (widx == IDX_HEIGHT)  height    <= wdata[HGT_W-1:0];
      if (widx == IDX_CLAMP)   clamp_min <= wdata[PIX_W-1:0];
      if (widx == IDX_CLIP)    clip_max  <= wdata[PIX_W-1:0];
    end
  end

  for (genvar k = 0; k < 9; k++) begin : g_coef
    localparam logic [COEF_W-1:0] RST_V = (k % 4 == 0) ? COEF_ONE : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)                           coef_q[k] <= RST_V;
      else if (wr && widx == IDX_COEF0 + k) coef_q[k] <= wdata[COEF_W-1:0];
    end
    assign coef[k*COEF_W +: COEF_W] = coef_q[k];
  end

  for (genvar c = 0; c < 3; c++) begin : g_ofs
    always_ff @(posedge clk) begin
      if (!rst_n)                          ofs_q[c] <= '0;
      else if (wr && widx == IDX_OFS0 + c) ofs_q[c] <= wdata[OFS_W-1:0];
    end
    assign offs[c*OFS_W +: OFS_W] = ofs_q[c];
  end

  always_comb begin
    rd_val = '0;
    if (widx == IDX_CTRL) begin
      rd_val[CB_START] = active;
      rd_val[CB_DONE]  = done;
      rd_val[CB_IDLE]  = !active;
      rd_val[CB_AUTO]  = auto_rs;
    end
    if (widx == IDX_FMT_IN)  rd_val = DATA_W'(fmt_in);
    if (widx == IDX_FMT_OUT) rd_val = DATA_W'(fmt_out);
    if (widx == IDX_WIDTH)   rd_val = DATA_W'(width);
    if (widx == IDX_HEIGHT)  rd_val = DATA_W'(height);
    if (widx == IDX_CLAMP)   rd_val = DATA_W'(clamp_min);
    if (widx == IDX_CLIP)    rd_val = DATA_W'(clip_max);
    for (int k = 0; k < 9; k++)
      if (widx == IDX_COEF0 + k) rd_val = DATA_W'(coef_q[k]);
    for (int c = 0; c < 3; c++)
      if (widx == IDX_OFS0 + c) rd_val = DATA_W'(ofs_q[c]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= rd_val;
    else         rdata <= '0;
  end

endmodule

// File: rtl/pfc_seq.sv
module pfc_seq
  import pfc_pkg::*;
#(
  parameter int WID_W = 14,
  parameter int HGT_W = 13
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_wr,
  input  logic             auto_rs,
  input  logic             cfg_ok,
  input  logic             pix_accept,
  input  logic [WID_W-1:0] sh_w,
  input  logic [HGT_W-1:0] sh_h,
  output logic             active,
  output logic             done,
  output logic             launch
);
  logic [WID_W-1:0] col;
  logic [HGT_W-1:0] row;
  logic             last_hit;

  assign launch   = !active && cfg_ok && (start_wr || (done && auto_rs));
  assign last_hit = active && pix_accept &&
                    is_last_pixel(32'(col), 32'(row), 32'(sh_w), 32'(sh_h));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      done   <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else begin
      done <= last_hit;
      if (launch) begin
        active <= 1'b1;
        col    <= '0;
        row    <= '0;
      end else if (last_hit) begin
        active <= 1'b0;
      end else if (active && pix_accept) begin
        if (32'(col) + 1 == 32'(sh_w)) begin
          col <= '0;
          row <= row + 1'b1;
        end else begin
          col <= col + 1'b1;
        end
      end
    end
  end

endmodule

// File: rtl/pfc_shadow.sv
module pfc_shadow
  import pfc_pkg::*;
#(
  parameter int WID_W     = 14,
  parameter int HGT_W     = 13,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 12
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [1:0]          fmt_in_d,
  input  logic [1:0]          fmt_out_d,
  input  logic [WID_W-1:0]    width_d,
  input  logic [HGT_W-1:0]    height_d,
  input  logic [9*COEF_W-1:0] coef_d,
  output logic [1:0]          fmt_in_q,
  output logic [1:0]          fmt_out_q,
  output logic [WID_W-1:0]    width_q,
  output logic [HGT_W-1:0]    height_q,
  output logic [9*COEF_W-1:0] coef_q
);
  localparam logic [COEF_W-1:0] COEF_ONE = COEF_W'(1) << COEF_FRAC;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fmt_in_q  <= FMT_YC422;
      fmt_out_q <= FMT_YC422;
      width_q   <= '0;
      height_q  <= '0;
    end else if (load) begin
      fmt_in_q  <= fmt_in_d;
      fmt_out_q <= fmt_out_d;
      width_q   <= width_d;
      height_q  <= height_d;
    end
  end

  for (genvar k = 0; k < 9; k++) begin : g_sh
    localparam logic [COEF_W-1:0] RST_V = (k % 4 == 0) ? COEF_ONE : '0;
    always_ff @(posedge clk) begin
      if (!rst_n)    coef_q[k*COEF_W +: COEF_W] <= RST_V;
      else if (load) coef_q[k*COEF_W +: COEF_W] <= coef_d[k*COEF_W +: COEF_W];
    end
  end

endmodule

// File: rtl/pixel_frame_ctl.sv
module pixel_frame_ctl
  import pfc_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 32,
  parameter int WID_W     = 14,
  parameter int HGT_W     = 13,
  parameter int COEF_W    = 16,
  parameter int COEF_FRAC = 12,
  parameter int OFS_W     = 16,
  parameter int PIX_W     = 10,
  parameter int MIN_W     = 64,
  parameter int MAX_W     = 8192,
  parameter int MIN_H     = 64,
  parameter int MAX_H     = 4320
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr,
  input  logic                reg_rd,
  input  logic [ADDR_W-1:0]   reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic                pix_accept,
  output logic                frame_en,
  output logic                frame_done,
  output logic [1:0]          cfg_fmt_in,
  output logic [1:0]          cfg_fmt_out,
  output logic [WID_W-1:0]    cfg_width,
  output logic [HGT_W-1:0]    cfg_height,
  output logic [9*COEF_W-1:0] cfg_coef,
  output logic [3*OFS_W-1:0]  cfg_offset,
  output logic [PIX_W-1:0]    cfg_clamp_min,
  output logic [PIX_W-1:0]    cfg_clip_max
);
  logic [1:0]          live_fmt_in, live_fmt_out;
  logic [WID_W-1:0]    live_width;
  logic [HGT_W-1:0]    live_height;
  logic [9*COEF_W-1:0] live_coef;
  logic                auto_rs, start_wr, launch, cfg_ok;

  assign cfg_ok = in_span(32'(live_width), MIN_W, MAX_W) &&
                  in_span(32'(live_height), MIN_H, MAX_H);

  pfc_regfile #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .WID_W(WID_W), .HGT_W(HGT_W),
    .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .OFS_W(OFS_W), .PIX_W(PIX_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr(reg_wr), .rd(reg_rd), .addr(reg_addr),
    .wdata(reg_wdata), .rdata(reg_rdata), .active(frame_en), .done(frame_done),
    .fmt_in(live_fmt_in), .fmt_out(live_fmt_out), .width(live_width),
    .height(live_height), .coef(live_coef), .offs(cfg_offset),
    .clamp_min(cfg_clamp_min), .clip_max(cfg_clip_max),
    .auto_rs(auto_rs), .start_wr(start_wr)
  );

  pfc_seq #(.WID_W(WID_W), .HGT_W(HGT_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .auto_rs(auto_rs),
    .cfg_ok(cfg_ok), .pix_accept(pix_accept), .sh_w(cfg_width), .sh_h(cfg_height),
    .active(frame_en), .done(frame_done), .launch(launch)
  );

  pfc_shadow #(
    .WID_W(WID_W), .HGT_W(HGT_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) u_shadow (
    .clk(clk), .rst_n(rst_n), .load(launch),
    .fmt_in_d(live_fmt_in), .fmt_out_d(live_fmt_out), .width_d(live_width),
    .height_d(live_height), .coef_d(live_coef),
    .fmt_in_q(cfg_fmt_in), .fmt_out_q(cfg_fmt_out), .width_q(cfg_width),
    .height_q(cfg_height), .coef_q(cfg_coef)
  );

endmodule

// File: rtl/pfc_chk.sv
module pfc_chk
  import pfc_pkg::*;
#(
  parameter int WID_W = 14,
  parameter int HGT_W = 13,
  parameter int MIN_W = 64,
  parameter int MAX_W = 8192,
  parameter int MIN_H = 64,
  parameter int MAX_H = 4320
) (
  input logic             clk,
  input logic             rst_n,
  input logic             frame_en,
  input logic             frame_done,
  input logic             pix_accept,
  input logic             auto_rs,
  input logic             start_wr,
  input logic             cfg_ok,
  input logic [WID_W-1:0] cfg_width,
  input logic [HGT_W-1:0] cfg_height
);

  // R5
  done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  // R5
  done_after_pixel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($past(frame_en && pix_accept) && !frame_en));

  // R7
  auto_relaunch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && auto_rs && cfg_ok) |=> frame_en);

  // R6
  halt_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_done && !auto_rs && !start_wr) |=> !frame_en);

  // R4
  legal_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_en |-> (in_span(32'(cfg_width), MIN_W, MAX_W) &&
                  in_span(32'(cfg_height), MIN_H, MAX_H)));

  // R8
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_en && $past(frame_en)) |-> ($stable(cfg_width) && $stable(cfg_height)));

endmodule

bind pixel_frame_ctl pfc_chk #(
  .WID_W(WID_W), .HGT_W(HGT_W), .MIN_W(MIN_W), .MAX_W(MAX_W),
  .MIN_H(MIN_H), .MAX_H(MAX_H)
) u_chk (
  .clk(clk), .rst_n(rst_n), .frame_en(frame_en), .frame_done(frame_done),
  .pix_accept(pix_accept), .auto_rs(auto_rs), .start_wr(start_wr),
  .cfg_ok(cfg_ok), .cfg_width(cfg_width), .cfg_height(cfg_height)
);

// File: tb/test_pixel_frame_ctl.sv
`timescale 1ns/1ps
module test_pixel_frame_ctl;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        pix_accept = 1'b0;
  logic        frame_en, frame_done;
  logic [1:0]  cfg_fmt_in, cfg_fmt_out;
  logic [13:0] cfg_width;
  logic [12:0] cfg_height;
  logic [143:0] cfg_coef;
  logic [47:0] cfg_offset;
  logic [9:0]  cfg_clamp_min, cfg_clip_max;

  always #2.5 clk = ~clk;

  pixel_frame_ctl i_pixel_frame_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .pix_accept(pix_accept), .frame_en(frame_en), .frame_done(frame_done),
    .cfg_fmt_in(cfg_fmt_in), .cfg_fmt_out(cfg_fmt_out), .cfg_width(cfg_width),
    .cfg_height(cfg_height), .cfg_coef(cfg_coef), .cfg_offset(cfg_offset),
    .cfg_clamp_min(cfg_clamp_min), .cfg_clip_max(cfg_clip_max)
  );

  int    n_run = 0, n_fail = 0;
  bit    finished = 1'b0;
  longint exp_q[$];
  string  tag_q[$];
  logic   rd_d = 1'b0;

  task automatic check(input string req, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  endtask

  // scoreboard monitor: compare read data the cycle after a read strobe
  always @(posedge clk) rd_d <= reg_rd;
  always @(negedge clk) begin
    if (rd_d) begin
      if (exp_q.size() == 0) check("R2 unexpected read", 1, 0);
      else check(tag_q.pop_front(), longint'(reg_rdata), exp_q.pop_front());
    end
  end

  task automatic wr(input int a, input int d);
    reg_addr = 8'(a); reg_wdata = 32'(d); reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, input longint e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    reg_addr = 8'(a); reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(output int n);
    n = 0;
    pix_accept = 1'b1;
    do begin
      @(negedge clk);
      n++;
    end while (!frame_done && n < 20000);
    pix_accept = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    check("watchdog", 1, 0);
    summary();
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1 fmt_in", cfg_fmt_in, 2);
    check("R1 fmt_out", cfg_fmt_out, 2);
    check("R1 K11", cfg_coef[0 +: 16], 4096);
    check("R1 K12", cfg_coef[16 +: 16], 0);
    check("R1 K22", cfg_coef[64 +: 16], 4096);
    check("R1 K33", cfg_coef[128 +: 16], 4096);
    check("R1 offsets", cfg_offset, 0);
    check("R1 clamp", cfg_clamp_min, 0);
    check("R1 clip", cfg_clip_max, 1023);
    check("R1 frame_en", frame_en, 0);
    rd(8'h00, 4, "R1 ctrl idle");

    // R2 map and unmapped reads
    rd(8'h050, 4096, "R2 K11 read");
    rd(8'h058, 0, "R2 K12 read");
    rd(8'h090, 4096, "R2 K33 read");
    rd(8'h010, 2, "R2 fmt_in read");
    rd(8'h0B8, 1023, "R2 clip read");
    rd(8'h004, 0, "R2 unaligned read");
    rd(8'h030, 0, "R2 hole read");
    rd(8'h0F8, 0, "R2 high read");
    wr(8'h054, 32'h0000_1234);
    rd(8'h050, 4096, "R2 unaligned write ignored");

    // R4 size range
    wr(8'h000, 1);
    check("R4 start refused zero size", frame_en, 0);
    wr(8'h020, 63); wr(8'h028, 64); wr(8'h000, 1);
    check("R4 width 63 refused", frame_en, 0);
    wr(8'h020, 8193); wr(8'h000, 1);
    check("R4 width 8193 refused", frame_en, 0);
    wr(8'h020, 64); wr(8'h028, 4321); wr(8'h000, 1);
    check("R4 height 4321 refused", frame_en, 0);
    rd(8'h00, 4, "R4 ctrl still idle");
    wr(8'h028, 64);
    check("R8 shadow untouched before launch", cfg_width, 0);

    // R9 unshadowed fields
    wr(8'h0A0, 32'h1234);
    check("R9 green offset", cfg_offset[16 +: 16], 32'h1234);
    wr(8'h0B0, 5);
    check("R9 clamp", cfg_clamp_min, 5);

    // R10 accepts while idle
    pix_accept = 1'b1;
    repeat (50) @(negedge clk);
    pix_accept = 1'b0;

    // R3 start
    wr(8'h010, 0); wr(8'h058, 32'h100);
    wr(8'h000, 1);
    check("R3 frame_en", frame_en, 1);
    check("R3 width shadow", cfg_width, 64);
    check("R3 fmt_in shadow", cfg_fmt_in, 0);
    check("R3 K12 shadow", cfg_coef[16 +: 16], 32'h100);
    rd(8'h00, 1, "R3 ctrl running");

    // R8 writes during frame
    wr(8'h020, 100); wr(8'h018, 1);
    rd(8'h020, 100, "R8 width readback");
    check("R8 width held", cfg_width, 64);
    check("R8 fmt_out held", cfg_fmt_out, 2);

    // R5 + R10 frame length
    run_frame(n);
    check("R10/R5 frame length 64x64", n, 4096);
    check("R5 done en low", frame_en, 0);
    @(negedge clk);
    check("R5 done one cycle", frame_done, 0);
    check("R6 stays idle", frame_en, 0);
    rd(8'h00, 4, "R6 ctrl idle");
    check("R8 width still old", cfg_width, 64);

    // R8 new size applies at next launch
    wr(8'h000, 1);
    check("R8 width new", cfg_width, 100);
    check("R8 fmt_out new", cfg_fmt_out, 1);
    run_frame(n);
    check("R8 frame length 100x64", n, 6400);
    @(negedge clk);

    // R7 continuous mode
    wr(8'h020, 64);
    wr(8'h000, 32'h81);
    rd(8'h00, 32'h81, "R7 ctrl running auto");
    run_frame(n);
    check("R7 frame1 length", n, 4096);
    @(negedge clk);
    check("R7 relaunch", frame_en, 1);
    check("R7 done cleared", frame_done, 0);
    run_frame(n);
    check("R7 frame2 length", n, 4096);
    @(negedge clk);
    check("R7 relaunch again", frame_en, 1);
    wr(8'h000, 0);
    rd(8'h00, 1, "R7 stop keeps frame");
    run_frame(n);
    check("R7 last frame length", n, 4096);
    @(negedge clk);
    check("R7 stopped", frame_en, 0);
    rd(8'h00, 4, "R7 ctrl idle");

    summary();
  end

endmodule